// File: doc/BRIEF.md
# External Data Memory Bus Controller

This controller sits between a processor core and an off-chip data memory. It drives a 13-bit address bus, a 16-bit bidirectional data bus, a line that selects one of two external banks (X or Y), and active-low read and write strobes. Each external access keeps its strobe low for a fixed number of cycles. That number comes from a wait-count register that holds only 1, 3 or 7 wait cycles.

The core sees a plain request/ready port. It raises `core_req` with the direction, bank, address and (for writes) data. It holds them until `core_rdy` pulses for one clock. On a read, `core_rdata` is valid in that same cycle. While no access runs, the address lines keep showing the last address used, and the data bus floats.

A second bus master can take the external bus with an active-low hold request. The controller grants it with an active-low hold acknowledge, and only between accesses. While the bus is granted, the controller releases the address, bank, strobe and data lines to high impedance. Core requests that arrive during a hold wait until the hold is removed. The hold request is taken as synchronous to `clk`.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset `ext_addr` is 0x000, `ext_rd_n` and `ext_wr_n` are high, `ext_hold_ack_n` is high and `core_rdy` is low.
- R2: When `cfg_we` is high, `cfg_wait` sets the wait count as follows: code 0 gives 1 wait, code 1 gives 3 waits, code 2 gives 7 waits. Code 3 is ignored and the previous setting stays. The reset setting is 7.
- R3: An accepted access with wait count W drives exactly one strobe low for W+1 consecutive cycles, starting in the cycle after acceptance. `ext_rd_n` is used for reads (`core_we`=0) and `ext_wr_n` for writes (`core_we`=1).
- R4: On a read, the value on `ext_data` in the last strobe-low cycle appears on `core_rdata` while `core_rdy` is high.
- R5: On a write, `ext_data` carries `core_wdata` in every strobe-low cycle.
- R6: `ext_bank` equals `core_bank` (0 = X, 1 = Y) during the access and keeps that value afterwards.
- R7: While no access runs, `ext_addr` keeps the address of the most recent access, including across a hold.
- R8: `ext_data` is high impedance whenever no write strobe is low.
- R9: While idle, a low `ext_hold_req_n` drives `ext_hold_ack_n` low one cycle later. While the acknowledge is low, the address, bank, strobe and data lines are all high impedance. The acknowledge returns high one cycle after the request goes high.
- R10: A hold request raised during an access is granted only after that access completes, never while a strobe is low.
- R11: A core request made while the bus is granted starts no access and gives no ready until the hold is removed. It is then carried out normally.
- R12: `core_rdy` is high for exactly one cycle per access. A request still high in that ready cycle does not start a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the wait-count setting |
| cfg_wait | input | 2 | Wait-count code (0: 1, 1: 3, 2: 7, 3: ignored) |
| core_req | input | 1 | Access request, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_bank | input | 1 | External bank, 0 = X, 1 = Y |
| core_addr | input | 13 | Word address |
| core_wdata | input | 16 | Write data |
| core_rdata | output | 16 | Read data, valid with `core_rdy` |
| core_rdy | output | 1 | One-cycle completion pulse |
| ext_addr | inout | 13 | External address, released during hold |
| ext_bank | inout | 1 | External bank select, released during hold |
| ext_rd_n | inout | 1 | Active-low read strobe, released during hold |
| ext_wr_n | inout | 1 | Active-low write strobe, released during hold |
| ext_data | inout | 16 | External data bus |
| ext_hold_req_n | input | 1 | Active-low bus hold request |
| ext_hold_ack_n | output | 1 | Active-low bus hold acknowledge |

## Verification
The bench builds the block with its default widths: 13 address bits, 16 data bits and a 3-bit wait counter. It sweeps every legal wait code across both banks, reads and writes, and several addresses, so every strobe length the register can produce is measured. The bench's memory model returns read data that changes on each strobe cycle, which shows whether sampling happens on the exact final cycle. During holds, and between accesses, bench drivers put patterns on the released lines, so high impedance is shown by reading those patterns back.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int WAIT_W = 3;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_XFER = 2'd1,
        BUS_HELD = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic wr;
        logic bank;
    } xfer_kind_t;

    // Map a wait code to a count; 0 marks an illegal code.
    function automatic logic [WAIT_W-1:0] wait_of(input logic [1:0] code);
        logic [WAIT_W-1:0] n;
        case (code)
            2'd0:    n = WAIT_W'(1);
            2'd1:    n = WAIT_W'(3);
            2'd2:    n = WAIT_W'(7);
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/xmem_wait_reg.sv
module xmem_wait_reg
    import xmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wait,
    output logic [WAIT_W-1:0] wait_n
);
    logic [WAIT_W-1:0] decoded;

    always_comb decoded = wait_of(cfg_wait);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_n <= WAIT_W'(7);
        end else if (cfg_we && decoded != '0) begin
            wait_n <= decoded;
        end
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_bank,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              hold_req_n,
    input  logic [DATA_W-1:0] bus_din,
    output bus_state_e        state,
    output xfer_kind_t        kind,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rdy_q
);
    logic [WAIT_W-1:0] cnt;
    logic              last;

    always_comb last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= BUS_IDLE;
            kind    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rdy_q   <= 1'b0;
            cnt     <= '0;
        end else begin
            rdy_q <= 1'b0;
            case (state)
                BUS_IDLE: begin
                    if (!hold_req_n) begin
                        state <= BUS_HELD;
                    end else if (core_req && !rdy_q) begin
                        state     <= BUS_XFER;
                        cnt       <= wait_n;
                        kind.wr   <= core_we;
                        kind.bank <= core_bank;
                        addr_q    <= core_addr;
                        wdata_q   <= core_wdata;
                    end
                end
                BUS_XFER: begin
                    if (last) begin
                        state <= BUS_IDLE;
                        rdy_q <= 1'b1;
                        if (!kind.wr) rdata_q <= bus_din;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BUS_HELD: begin
                    if (hold_req_n) state <= BUS_IDLE;
                end
                default: state <= BUS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xmem_pad.sv
module xmem_pad #(
    parameter int W = 1
) (
    input  logic         en,
    input  logic [W-1:0] d,
    inout  wire  [W-1:0] pad
);
    assign pad = en ? d : {W{1'bz}};
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wait,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_bank,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_rdy,
    inout  wire  [ADDR_W-1:0] ext_addr,
    inout  wire               ext_bank,
    inout  wire               ext_rd_n,
    inout  wire               ext_wr_n,
    inout  wire  [DATA_W-1:0] ext_data,
    input  logic              ext_hold_req_n,
    output logic              ext_hold_ack_n
);
    logic [WAIT_W-1:0] wait_n;
    bus_state_e        state;
    xfer_kind_t        kind;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rdy_q;
    logic              own_bus;
    logic              held;
    logic              rd_act;
    logic              wr_act;
    logic              rd_n_int;
    logic              wr_n_int;

    xmem_wait_reg u_wait (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_wait (cfg_wait),
        .wait_n   (wait_n)
    );

    xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wait_n     (wait_n),
        .core_req   (core_req),
        .core_we    (core_we),
        .core_bank  (core_bank),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .hold_req_n (ext_hold_req_n),
        .bus_din    (ext_data),
        .state      (state),
        .kind       (kind),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .rdata_q    (rdata_q),
        .rdy_q      (rdy_q)
    );

    always_comb begin
        held     = (state == BUS_HELD);
        own_bus  = !held;
        rd_act   = (state == BUS_XFER) && !kind.wr;
        wr_act   = (state == BUS_XFER) && kind.wr;
        rd_n_int = !rd_act;
        wr_n_int = !wr_act;
    end

    xmem_pad #(.W(ADDR_W)) u_pad_addr (.en(own_bus), .d(addr_q),    .pad(ext_addr));
    xmem_pad #(.W(1))      u_pad_bank (.en(own_bus), .d(kind.bank), .pad(ext_bank));
    xmem_pad #(.W(1))      u_pad_rd   (.en(own_bus), .d(rd_n_int),  .pad(ext_rd_n));
    xmem_pad #(.W(1))      u_pad_wr   (.en(own_bus), .d(wr_n_int),  .pad(ext_wr_n));
    xmem_pad #(.W(DATA_W)) u_pad_data (.en(wr_act),  .d(wdata_q),   .pad(ext_data));

    assign core_rdata     = rdata_q;
    assign core_rdy       = rdy_q;
    assign ext_hold_ack_n = !held;
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              core_rdy,
    input logic              rd_act,
    input logic              wr_act,
    input logic              held,
    input logic [ADDR_W-1:0] addr_q,
    input logic [WAIT_W-1:0] wait_n
);
    AST_WAIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (wait_n == 3'd1) || (wait_n == 3'd3) || (wait_n == 3'd7)); // R2

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(rd_act && wr_act)); // R3

    AST_RDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        core_rdy |-> $past(rd_act || wr_act)); // R3

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        core_rdy |=> !core_rdy); // R12

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(rd_act || wr_act) |=> ((rd_act || wr_act) || $stable(addr_q))); // R7

    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
        held |-> !(rd_act || wr_act)); // R9

    AST_GRANT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> !$past(rd_act || wr_act)); // R10
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .core_rdy (core_rdy),
    .rd_act   (rd_act),
    .wr_act   (wr_act),
    .held     (held),
    .addr_q   (addr_q),
    .wait_n   (wait_n)
);

// File: tb/test_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module test_xmem_bus_ctrl;
    localparam int AW = 13;
    localparam int DW = 16;
    localparam logic [AW-1:0] PROBE_A = 13'h15A6;
    localparam logic [DW-1:0] PROBE_D = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_wait = 2'd0;
    logic          core_req = 1'b0;
    logic          core_we = 1'b0;
    logic          core_bank = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;
    logic          core_rdy;
    wire  [AW-1:0] ext_addr;
    wire           ext_bank;
    wire           ext_rd_n;
    wire           ext_wr_n;
    wire  [DW-1:0] ext_data;
    logic          ext_hold_req_n = 1'b1;
    logic          ext_hold_ack_n;

    logic          probe_on = 1'b0;
    logic          probe_d_on = 1'b0;
    logic [DW-1:0] mem [64];
    logic [2:0]    strobe_k = '0;
    logic [DW-1:0] exp_wd = '0;
    int            wr_bad = 0;
    int            checks = 0;
    int            fails = 0;
    int            cycles = 0;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    xmem_bus_ctrl i_xmem_bus_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
        .core_req(core_req), .core_we(core_we), .core_bank(core_bank),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_rdy(core_rdy),
        .ext_addr(ext_addr), .ext_bank(ext_bank), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_data(ext_data),
        .ext_hold_req_n(ext_hold_req_n), .ext_hold_ack_n(ext_hold_ack_n)
    );

    // Memory model and second bus master.
    logic          mdl_rd;
    logic [5:0]    mdl_idx;
    logic [DW-1:0] rd_val;
    assign mdl_rd  = ext_hold_ack_n && (ext_rd_n == 1'b0);
    assign mdl_idx = {ext_bank, ext_addr[4:0]};
    assign rd_val  = mem[mdl_idx] ^ {13'd0, strobe_k};

    assign ext_addr = probe_on ? PROBE_A : {AW{1'bz}};
    assign ext_bank = probe_on ? 1'b0 : 1'bz;
    assign ext_rd_n = probe_on ? 1'b0 : 1'bz;
    assign ext_wr_n = probe_on ? 1'b0 : 1'bz;
    assign ext_data = (probe_on || probe_d_on) ? PROBE_D :
                      (mdl_rd ? rd_val : {DW{1'bz}});

    always @(posedge clk) begin
        strobe_k <= mdl_rd ? strobe_k + 3'd1 : 3'd0;
        if (ext_hold_ack_n && ext_wr_n == 1'b0 && !probe_on) begin
            if (ext_data != exp_wd) wr_bad <= wr_bad + 1;
            mem[mdl_idx] <= ext_data;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_wait(input logic [1:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wait = code;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; hold_at > 0 raises the hold request in that cycle of the access.
    task automatic run_xfer(input logic we, input logic bank, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input int hold_at,
                            output logic [DW-1:0] rd, output int lows,
                            output int cyc, output int ack_bad);
        int wb0;
        lows = 0; cyc = 0; ack_bad = 0; rd = '0;
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_bank = bank; core_addr = a;
        core_wdata = wd; exp_wd = wd;
        wb0 = wr_bad;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cyc++;
            if (cyc == hold_at) ext_hold_req_n = 1'b0;
            if (ext_hold_ack_n && (ext_rd_n == 1'b0 || ext_wr_n == 1'b0)) begin
                lows++;
                if (we && ext_bank != bank) ack_bad++;
            end
            if (ext_hold_ack_n == 1'b0 && !core_rdy) ack_bad++;
            if (core_rdy) begin
                rd = core_rdata;
                break;
            end
        end
        // Keep the request high through the ready cycle (R12).
        @(negedge clk);
        chk(core_rdy == 1'b0, "R12 ready width", int'(core_rdy), 0);
        if (ext_hold_ack_n)
            chk(ext_rd_n == 1'b1 && ext_wr_n == 1'b1, "R12 no restart",
                int'({ext_rd_n, ext_wr_n}), 3);
        core_req = 1'b0;
        if (we) chk(wr_bad == wb0, "R5 write data held", wr_bad - wb0, 0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        logic [DW-1:0] rd;
        int lows, cyc, abad, w;
        logic [AW-1:0] a, last_a;
        logic [DW-1:0] v;
        logic          last_b;

        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ext_addr == '0, "R1 address", int'(ext_addr), 0);
        chk(ext_rd_n && ext_wr_n, "R1 strobes", int'({ext_rd_n, ext_wr_n}), 3);
        chk(ext_hold_ack_n == 1'b1, "R1 hold ack", int'(ext_hold_ack_n), 1);
        chk(core_rdy == 1'b0, "R1 ready", int'(core_rdy), 0);

        // R2 reset wait count is 7
        run_xfer(1'b1, 1'b0, 13'h0003, 16'h1234, 0, rd, lows, cyc, abad);
        chk(lows == 8, "R2 reset wait 7", lows, 8);

        // Sweep all legal codes, banks, directions, addresses.
        for (int code = 0; code < 3; code++) begin
            set_wait(2'(code));
            w = (code == 0) ? 1 : (code == 1) ? 3 : 7;
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 4; i++) begin
                    a = {8'(i * 53 + code * 7 + b), 5'(code * 4 + i)};
                    v = 16'(16'h3C00 + code * 256 + b * 64 + i * 9 + 1);
                    run_xfer(1'b1, 1'(b), a, v, 0, rd, lows, cyc, abad);
                    chk(lows == w + 1, "R3 write strobe length", lows, w + 1);
                    chk(cyc == w + 2, "R3 write start timing", cyc, w + 2);
                    chk(abad == 0, "R6 bank during write", abad, 0);
                    chk(ext_addr == a, "R7 address held after write", int'(ext_addr), int'(a));
                    chk(ext_bank == 1'(b), "R6 bank held", int'(ext_bank), b);
                    run_xfer(1'b0, 1'(b), a, 16'h0, 0, rd, lows, cyc, abad);
                    chk(lows == w + 1, "R3 read strobe length", lows, w + 1);
                    chk(rd == (v ^ DW'(w)), "R4 read sampled on last cycle",
                        int'(rd), int'(v ^ DW'(w)));
                    // R8 data bus released between accesses
                    probe_d_on = 1'b1;
                    #0.5;
                    chk(ext_data == PROBE_D, "R8 data released", int'(ext_data), int'(PROBE_D));
                    probe_d_on = 1'b0;
                    last_a = a; last_b = 1'(b);
                end
            end
        end

        // R2 illegal code ignored
        set_wait(2'd1);
        set_wait(2'd3);
        run_xfer(1'b0, last_b, last_a, 16'h0, 0, rd, lows, cyc, abad);
        chk(lows == 4, "R2 code 3 ignored", lows, 4);

        // R9 grant while idle and release of all lines
        @(negedge clk);
        ext_hold_req_n = 1'b0;
        @(negedge clk);
        chk(ext_hold_ack_n == 1'b0, "R9 grant one cycle later", int'(ext_hold_ack_n), 0);
        probe_on = 1'b1;
        #0.5;
        chk(ext_addr == PROBE_A, "R9 address released", int'(ext_addr), int'(PROBE_A));
        chk(ext_rd_n == 1'b0 && ext_wr_n == 1'b0 && ext_bank == 1'b0, "R9 strobes and bank released",
            int'({ext_rd_n, ext_wr_n, ext_bank}), 0);
        chk(ext_data == PROBE_D, "R9 data released", int'(ext_data), int'(PROBE_D));
        @(negedge clk);
        probe_on = 1'b0;
        ext_hold_req_n = 1'b1;
        @(negedge clk);
        chk(ext_hold_ack_n == 1'b1, "R9 release one cycle later", int'(ext_hold_ack_n), 1);
        chk(ext_addr == last_a, "R7 address kept across hold", int'(ext_addr), int'(last_a));

        // R11 request during hold stalls
        @(negedge clk);
        ext_hold_req_n = 1'b0;
        @(negedge clk);
        core_req = 1'b1; core_we = 1'b0; core_bank = last_b; core_addr = last_a;
        abad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (core_rdy || ext_hold_ack_n) abad++;
        end
        chk(abad == 0, "R11 no access during hold", abad, 0);
        ext_hold_req_n = 1'b1;
        lows = 0; rd = '0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ext_hold_ack_n && ext_rd_n == 1'b0) lows++;
            if (core_rdy) begin
                rd = core_rdata;
                break;
            end
        end
        core_req = 1'b0;
        chk(lows == 4, "R11 stalled read strobe length", lows, 4);
        v = mem[{last_b, last_a[4:0]}];
        chk(rd == (v ^ 16'd3), "R11 stalled read data", int'(rd), int'(v ^ 16'd3));

        // R10 hold raised mid-access waits for completion
        set_wait(2'd2);
        run_xfer(1'b1, 1'b1, 13'h0A1F, 16'hBEEF, 3, rd, lows, cyc, abad);
        chk(abad == 0, "R10 no grant during strobe", abad, 0);
        chk(lows == 8, "R10 access completes fully", lows, 8);
        chk(ext_hold_ack_n == 1'b0, "R10 grant after completion", int'(ext_hold_ack_n), 0);
        @(negedge clk);
        ext_hold_req_n = 1'b1;
        @(negedge clk);
        run_xfer(1'b0, 1'b1, 13'h0A1F, 16'h0, 0, rd, lows, cyc, abad);
        chk(rd == (16'hBEEF ^ 16'd7), "R10 write landed", int'(rd), int'(16'hBEEF ^ 16'd7));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule